// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a register-programmed I2C master that moves one byte at a time under software control. Software writes a small set of memory-mapped registers. It raises start and stop conditions, loads an address or data byte to send, or releases the bus to clock in a byte from a slave. When receiving, it chooses whether the master answers with ACK or NACK.

After every byte the master stops in a wait state with SCL held low and emits a one-cycle interrupt. A control bit selects whether this stop falls after the 8th clock, before the acknowledge slot, or after the 9th clock. Software continues the transfer by writing the wait-release trigger. The SCL low and high phases each last a programmable number of clock cycles.

Both bus lines are open drain. Each is an output enable that pulls the line low, plus an input that passes through a synchronizer. The start and stop detector feeds the busy and stop-seen flags.

Top module: `i2cm_byte_ctrl`

## Requirements
- R1: After reset every readable register reads 0, both output enables are 0 and the interrupt is low.
- R2: A start trigger (trigger register 0x0C bit 1), given while the controller is enabled (control0 0x08 bit 7) and start output is allowed (control1 0x20 bit 1), makes SDA fall while SCL is high. The busy flag (status 0x10 bit 6) then becomes 1. With control1 bit 1 clear, the trigger leaves both lines released and busy at 0.
- R3: A write to the data register (0x00) in the wait state sends the byte MSB first over 8 SCL clocks, followed by an acknowledge clock. Status bit 8 then reads 1 when the slave pulled SDA low in that slot.
- R4: When the slave leaves SDA high in the acknowledge slot of a sent byte, status bit 8 reads 0.
- R5: A wait-release trigger (trigger bit 2) in the wait state after a byte receives a byte MSB first. With control0 bit 1 clear, the interrupt and the wait come after the 8th clock, with SCL held low. The data register then holds the received byte.
- R6: In the acknowledge slot of a received byte, the master drives SDA low when control0 bit 0 is 1 and releases SDA (NACK) when it is 0.
- R7: A stop trigger (trigger bit 0) raises SDA while SCL is high and releases both lines. Status bit 4 then reads 1 and busy reads 0.
- R8: When several trigger bits are written together in the wait state, stop beats start and start beats wait release.
- R9: Clearing control0 bit 7 returns the byte engine to idle in the next cycle, releases both lines and clears all status flags.
- R10: Each SCL low phase lasts the value of the low-width register (0x24) in clock cycles, and each high phase lasts the value of the high-width register (0x28). Both values must be at least 4.
- R11: The interrupt is a pulse exactly one cycle wide, given once per wait entry that control0 bit 1 selects (bit 1 = 1 selects the post-9th-clock wait, bit 1 = 0 the post-8th-clock wait).
- R12: Triggers are ignored while the controller is disabled, and a data write while idle starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and bus timing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | One-cycle byte-boundary interrupt |
| sclOe | output | 1 | Pull SCL low when 1 |
| sclIn | input | 1 | SCL line level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sdaIn | input | 1 | SDA line level |

## Verification
Within one trigger write, the stop, start and wait-release actions can be requested in the same cycle. The bench provokes this by writing start together with stop, and release together with start, while the master waits. The stop-plus-start case is judged by the stop-seen flag, a cleared busy flag and released lines. The release-plus-start case is judged by the absence of any interrupt while busy stays set and SCL stays held low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_CTL0 = 8'h08;
  localparam logic [7:0] OFS_TRIG = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_CTL1 = 8'h20;
  localparam logic [7:0] OFS_LOW  = 8'h24;
  localparam logic [7:0] OFS_HIGH = 8'h28;

  localparam int B_EN = 7, B_AT9 = 1, B_ACKEN = 0;
  localparam int B_REL = 2, B_STA = 1, B_STP = 0;
  localparam int B_ACK = 8, B_BUSY = 6, B_STOP = 4;
  localparam int B_FAST = 7, B_STAOK = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_STA_A, S_STA_B, S_STA_C, S_BIT_LO, S_BIT_HI,
    S_WAIT8, S_WAIT9, S_STP_A, S_STP_B, S_STP_C
  } ctlState_e;

  typedef enum logic [1:0] {SDA_REL, SDA_LOW, SDA_DATA} sdaSel_e;

  typedef struct packed {
    logic    tmrLoad;
    logic    tmrHigh;
    logic    shiftEn;
    logic    loadTx;
    logic    ackCapture;
    logic    irqPulse;
    logic    sclLow;
    sdaSel_e sdaSel;
  } ctlStrobe_t;
endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CNT_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  ctlStrobe_t       str,
  output logic             en,
  output logic             waitAt9,
  output logic             ackEn,
  output logic             startOutEn,
  output logic             dataWr,
  output logic             trigRelease,
  output logic             trigStart,
  output logic             trigStop,
  output logic             tmrDone,
  output logic             irq,
  output logic             sclOe,
  input  logic             sclIn,
  output logic             sdaOe,
  input  logic             sdaIn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic fastMode;
  logic [CNT_W-1:0] lowWidth, highWidth, tmr;
  logic [7:0] shiftReg;
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sdaPrev, startDet, stopDet;
  logic ackRcvd, busy, stopSeen;
  logic trigWr;
  logic unusedBits;

  assign unusedBits = ^wdata[BUS_W-1:CNT_W];

  assign trigWr      = wrEn && (addr == OFS_TRIG) && en;
  assign trigRelease = trigWr && wdata[B_REL];
  assign trigStart   = trigWr && wdata[B_STA];
  assign trigStop    = trigWr && wdata[B_STP];
  assign dataWr      = wrEn && (addr == OFS_DATA) && en;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en <= 1'b0; waitAt9 <= 1'b0; ackEn <= 1'b0;
      fastMode <= 1'b0; startOutEn <= 1'b0;
      lowWidth <= '0; highWidth <= '0;
    end else if (wrEn) begin
      case (addr)
        OFS_CTL0: begin
          en <= wdata[B_EN]; waitAt9 <= wdata[B_AT9]; ackEn <= wdata[B_ACKEN];
        end
        OFS_CTL1: begin fastMode <= wdata[B_FAST]; startOutEn <= wdata[B_STAOK]; end
        OFS_LOW:  lowWidth  <= wdata[CNT_W-1:0];
        OFS_HIGH: highWidth <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // input synchronizers and condition detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1; sdaSync <= '1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sdaPrev <= sdaS;
    end
  end
  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign startDet = sclS && sdaPrev && !sdaS;
  assign stopDet  = sclS && !sdaPrev && sdaS;

  // phase timer, shifter, flags, interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0; shiftReg <= '0; irq <= 1'b0;
      ackRcvd <= 1'b0; busy <= 1'b0; stopSeen <= 1'b0;
    end else begin
      if (str.tmrLoad) tmr <= (str.tmrHigh ? highWidth : lowWidth) - ONE;
      else if (tmr != '0) tmr <= tmr - ONE;
      if (str.loadTx) shiftReg <= wdata[7:0];
      else if (str.shiftEn) shiftReg <= {shiftReg[6:0], sdaS};
      irq <= str.irqPulse;
      if (!en) begin
        ackRcvd <= 1'b0; busy <= 1'b0; stopSeen <= 1'b0;
      end else begin
        if (str.ackCapture) ackRcvd <= !sdaS;
        if (startDet) begin busy <= 1'b1; stopSeen <= 1'b0; end
        else if (stopDet) begin busy <= 1'b0; stopSeen <= 1'b1; end
      end
    end
  end
  assign tmrDone = (tmr == '0);

  assign sclOe = str.sclLow;
  assign sdaOe = (str.sdaSel == SDA_LOW) || ((str.sdaSel == SDA_DATA) && !shiftReg[7]);

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_DATA: rdata[7:0] = shiftReg;
      OFS_CTL0: begin rdata[B_EN] = en; rdata[B_AT9] = waitAt9; rdata[B_ACKEN] = ackEn; end
      OFS_STAT: begin rdata[B_ACK] = ackRcvd; rdata[B_BUSY] = busy; rdata[B_STOP] = stopSeen; end
      OFS_CTL1: begin rdata[B_FAST] = fastMode; rdata[B_STAOK] = startOutEn; end
      OFS_LOW:  rdata[CNT_W-1:0] = lowWidth;
      OFS_HIGH: rdata[CNT_W-1:0] = highWidth;
      default: ;
    endcase
  end

  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rstN) irq |=> !irq)
    else $error("irq wider than one cycle");
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN) (en && startDet) |=> busy)
    else $error("busy not set by start");
  p_stop_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (en && stopDet && !startDet) |=> (!busy && stopSeen))
    else $error("stop flags wrong");
  p_ack_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (en && str.ackCapture) |=> (ackRcvd == !$past(sdaS)))
    else $error("ack flag mismatch");
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       waitAt9,
  input  logic       ackEn,
  input  logic       startOutEn,
  input  logic       dataWr,
  input  logic       trigRelease,
  input  logic       trigStart,
  input  logic       trigStop,
  input  logic       tmrDone,
  output ctlStrobe_t str
);
  ctlState_e state, nxtState;
  logic [3:0] bitCnt, nxtBit;
  logic rxMode, nxtRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; bitCnt <= '0; rxMode <= 1'b0;
    end else if (!en) begin
      state <= S_IDLE; bitCnt <= '0; rxMode <= 1'b0;
    end else begin
      state <= nxtState; bitCnt <= nxtBit; rxMode <= nxtRx;
    end
  end

  always_comb begin
    nxtState = state; nxtBit = bitCnt; nxtRx = rxMode;
    str = '0;
    str.sclLow = (state == S_STA_A) || (state == S_BIT_LO) || (state == S_WAIT8) ||
                 (state == S_WAIT9) || (state == S_STP_A);
    case (state)
      S_STA_C, S_WAIT8, S_WAIT9, S_STP_A, S_STP_B: str.sdaSel = SDA_LOW;
      S_BIT_LO, S_BIT_HI:
        if (bitCnt < 4'd8) str.sdaSel = rxMode ? SDA_REL : SDA_DATA;
        else               str.sdaSel = (rxMode && ackEn) ? SDA_LOW : SDA_REL;
      default: str.sdaSel = SDA_REL;
    endcase
    case (state)
      S_IDLE: if (trigStart && startOutEn) begin
        nxtState = S_STA_B; str.tmrLoad = 1'b1; str.tmrHigh = 1'b1;
      end
      S_STA_A: if (tmrDone) begin nxtState = S_STA_B; str.tmrLoad = 1'b1; str.tmrHigh = 1'b1; end
      S_STA_B: if (tmrDone) begin nxtState = S_STA_C; str.tmrLoad = 1'b1; str.tmrHigh = 1'b1; end
      S_STA_C: if (tmrDone) nxtState = S_WAIT9;
      S_BIT_LO: if (tmrDone) begin nxtState = S_BIT_HI; str.tmrLoad = 1'b1; str.tmrHigh = 1'b1; end
      S_BIT_HI: if (tmrDone) begin
        if (bitCnt == 4'd8) begin
          str.ackCapture = !rxMode; str.irqPulse = waitAt9; nxtState = S_WAIT9;
        end else begin
          str.shiftEn = 1'b1;
          if (bitCnt == 4'd7 && !waitAt9) begin
            str.irqPulse = 1'b1; nxtState = S_WAIT8;
          end else begin
            nxtBit = bitCnt + 4'd1; nxtState = S_BIT_LO; str.tmrLoad = 1'b1;
          end
        end
      end
      S_WAIT8: if (trigRelease) begin
        nxtBit = 4'd8; nxtState = S_BIT_LO; str.tmrLoad = 1'b1;
      end
      S_WAIT9: begin
        if (trigStop) begin
          nxtState = S_STP_A; str.tmrLoad = 1'b1;
        end else if (trigStart && startOutEn) begin
          nxtState = S_STA_A; str.tmrLoad = 1'b1;
        end else if (dataWr) begin
          str.loadTx = 1'b1; nxtRx = 1'b0; nxtBit = '0; nxtState = S_BIT_LO; str.tmrLoad = 1'b1;
        end else if (trigRelease) begin
          nxtRx = 1'b1; nxtBit = '0; nxtState = S_BIT_LO; str.tmrLoad = 1'b1;
        end
      end
      S_STP_A: if (tmrDone) begin nxtState = S_STP_B; str.tmrLoad = 1'b1; str.tmrHigh = 1'b1; end
      S_STP_B: if (tmrDone) begin nxtState = S_STP_C; str.tmrLoad = 1'b1; str.tmrHigh = 1'b1; end
      S_STP_C: if (tmrDone) nxtState = S_IDLE;
      default: nxtState = S_IDLE;
    endcase
  end

  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rstN) !en |=> state == S_IDLE)
    else $error("engine not idle after disable");
  p_bit_limit_r3: assert property (@(posedge clk) disable iff (!rstN) bitCnt <= 4'd8)
    else $error("bit counter out of range");
  p_stop_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (en && state == S_WAIT9 && trigStop) |=> state == S_STP_A)
    else $error("stop lost priority");
endmodule

// File: rtl/i2cm_byte_ctrl.sv
module i2cm_byte_ctrl
  import i2cm_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CNT_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [7:0]       regAddr,
  input  logic [BUS_W-1:0] regWdata,
  output logic [BUS_W-1:0] regRdata,
  output logic             irq,
  output logic             sclOe,
  input  logic             sclIn,
  output logic             sdaOe,
  input  logic             sdaIn
);
  ctlStrobe_t str;
  logic en, waitAt9, ackEn, startOutEn, dataWr, trigRelease, trigStart, trigStop, tmrDone;

  i2cm_datapath #(.BUS_W(BUS_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(regWr), .addr(regAddr), .wdata(regWdata),
    .rdata(regRdata), .str(str), .en(en), .waitAt9(waitAt9), .ackEn(ackEn),
    .startOutEn(startOutEn), .dataWr(dataWr), .trigRelease(trigRelease),
    .trigStart(trigStart), .trigStop(trigStop), .tmrDone(tmrDone), .irq(irq),
    .sclOe(sclOe), .sclIn(sclIn), .sdaOe(sdaOe), .sdaIn(sdaIn)
  );

  i2cm_ctrl ctl_i (
    .clk(clk), .rstN(rstN), .en(en), .waitAt9(waitAt9), .ackEn(ackEn),
    .startOutEn(startOutEn), .dataWr(dataWr), .trigRelease(trigRelease),
    .trigStart(trigStart), .trigStop(trigStop), .tmrDone(tmrDone), .str(str)
  );
endmodule

// File: tb/i2cm_byte_ctrl_tb.sv
module i2cm_byte_ctrl_tb_top;
  localparam int WL = 6, WH = 5;
  // row: {op[1:0], byte[7:0], flag}; op 1 send, 2 receive wait@9, 3 receive wait@8
  localparam logic [10:0] VEC [6] = '{
    {2'd1, 8'hA5, 1'b1}, {2'd1, 8'h3C, 1'b0}, {2'd2, 8'h96, 1'b1},
    {2'd2, 8'h5A, 1'b0}, {2'd3, 8'hC3, 1'b1}, {2'd1, 8'hFF, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq, sclOe, sdaOe, slvLow;
  wire sclLine = !sclOe;
  wire sdaLine = !(sdaOe || slvLow);

  int total = 0, bad = 0, irqCnt = 0, fallTotal = 0, riseTotal = 0;
  int fallBase = 0, riseBase = 0, slvMode = 0;
  logic [7:0] slvByte = '0;
  logic slvAck = 1'b0, done = 1'b0;
  logic [15:0] sdaHist = '0;

  i2cm_byte_ctrl dut_i (.clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sclOe(sclOe), .sclIn(sclLine),
    .sdaOe(sdaOe), .sdaIn(sdaLine));

  always #2 clk = ~clk;
  always @(negedge clk) if (irq) irqCnt++;
  always @(negedge sclLine) fallTotal++;
  always @(posedge sclLine) begin riseTotal++; sdaHist = {sdaHist[14:0], sdaLine}; end

  // bench slave: acknowledges sent bytes or shifts out its own byte
  always_comb begin
    automatic int k = fallTotal - fallBase;
    automatic logic [7:0] sh = slvByte << k[2:0];
    if (slvMode == 1) slvLow = (k == 8) && slvAck;
    else if (slvMode == 2) slvLow = (k < 8) && !sh[7];
    else slvLow = 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdata;
  endtask

  task automatic arm(input int m, input logic [7:0] b, input logic a);
    fallBase = fallTotal; riseBase = riseTotal; slvMode = m; slvByte = b; slvAck = a;
  endtask

  task automatic waitIrq(input int base);
    for (int n = 0; n < 2000 && irqCnt == base; n++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int base, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h08, v); chk("R1 ctl0", v, 0);
    rd(8'h10, v); chk("R1 status", v, 0);
    rd(8'h24, v); chk("R1 low width", v, 0);
    chk("R1 lines", {30'b0, sclOe, sdaOe}, 0);
    chk("R1 irq", irqCnt, 0);

    wr(8'h24, WL); wr(8'h28, WH);
    // R12 trigger ignored while disabled
    wr(8'h20, 32'h02); wr(8'h0C, 32'h2);
    repeat (30) @(negedge clk);
    rd(8'h10, v); chk("R12 disabled start busy", v, 0);
    chk("R12 disabled start lines", {30'b0, sclOe, sdaOe}, 0);
    // R12 data write in idle
    wr(8'h08, 32'h83); wr(8'h00, 32'h55);
    repeat (30) @(negedge clk);
    chk("R12 idle data write scl", sclOe, 0);
    // R2 start refused without start output enable
    wr(8'h20, 32'h80); wr(8'h0C, 32'h2);
    repeat (30) @(negedge clk);
    rd(8'h10, v); chk("R2 start refused busy", v[6], 0);
    chk("R2 start refused lines", {30'b0, sclOe, sdaOe}, 0);
    // R2 start
    wr(8'h20, 32'h82); wr(8'h0C, 32'h2);
    repeat (30) @(negedge clk);
    rd(8'h10, v); chk("R2 busy after start", v[6], 1);
    chk("R2 scl held after start", sclOe, 1);
    chk("R2 no irq for start", irqCnt, 0);

    foreach (VEC[i]) begin
      automatic logic [1:0] op = VEC[i][10:9];
      automatic logic [7:0] b = VEC[i][8:1];
      automatic logic f = VEC[i][0];
      base = irqCnt;
      if (op == 2'd1) begin
        arm(1, b, f);
        wr(8'h00, {24'b0, b});
        if (i == 0) begin
          while (sclOe) @(negedge clk);
          cnt = 0; while (!sclOe) begin cnt++; @(negedge clk); end
          chk("R10 high phase", cnt, WH);
          cnt = 0; while (sclOe) begin cnt++; @(negedge clk); end
          chk("R10 low phase", cnt, WL);
        end
        waitIrq(base);
        repeat (3) @(negedge clk);
        chk("R3 bus byte", sdaHist[8:1], b);
        rd(8'h10, v); chk(f ? "R3 ack flag" : "R4 nack flag", v[8], f);
        chk("R11 one pulse after 9th", irqCnt, base + 1);
      end else if (op == 2'd2) begin
        wr(8'h08, {24'b0, 8'h82 | {7'b0, f}});
        arm(2, b, 1'b0);
        wr(8'h0C, 32'h4);
        waitIrq(base);
        repeat (3) @(negedge clk);
        rd(8'h00, v); chk("R5 received byte", v[7:0], b);
        chk(f ? "R6 master ack" : "R6 master nack", sdaHist[0], !f);
      end else begin
        wr(8'h08, {24'b0, 8'h80 | {7'b0, f}});
        arm(2, b, 1'b0);
        wr(8'h0C, 32'h4);
        waitIrq(base);
        repeat (20) @(negedge clk);
        rd(8'h00, v); chk("R5 byte at 8th clock", v[7:0], b);
        chk("R5 clocks before wait", riseTotal - riseBase, 8);
        chk("R5 scl held in wait", sclOe, 1);
        chk("R11 single irq at 8th", irqCnt, base + 1);
        wr(8'h08, {24'b0, 8'h82 | {7'b0, f}});
        wr(8'h0C, 32'h4);
        waitIrq(base + 1);
        repeat (3) @(negedge clk);
        chk("R6 ack after 8th wait", sdaHist[0], !f);
        chk("R11 irq after 9th", irqCnt, base + 2);
      end
      wr(8'h08, 32'h83);
    end

    arm(0, 8'h00, 1'b0);
    // R8 start beats release
    base = irqCnt;
    wr(8'h0C, 32'h6);
    repeat (80) @(negedge clk);
    chk("R8 start over release irq", irqCnt, base);
    rd(8'h10, v); chk("R8 start over release busy", v[6], 1);
    chk("R8 start over release scl", sclOe, 1);
    // R8 stop beats start, R7 stop flags
    wr(8'h0C, 32'h3);
    repeat (60) @(negedge clk);
    rd(8'h10, v);
    chk("R7 stop seen", v[4], 1);
    chk("R7 busy cleared", v[6], 0);
    chk("R8 stop over start lines", {30'b0, sclOe, sdaOe}, 0);
    // R9 disable mid transfer
    wr(8'h0C, 32'h2);
    repeat (30) @(negedge clk);
    rd(8'h10, v); chk("R9 busy before disable", v[6], 1);
    wr(8'h08, 32'h00);
    @(negedge clk);
    chk("R9 lines released", {30'b0, sclOe, sdaOe}, 0);
    rd(8'h10, v); chk("R9 status cleared", v, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule